// File: doc/BRIEF.md
# Multi-Size Sampled Tag Profiler

This block watches the stream of block addresses sent to a large last-level cache. From that stream it estimates how well the same workload would hit in caches of four sizes: all of the main cache's sets, one half, one quarter and one eighth of them. It stores tags only. A filter passes one main-cache set in every `SAMPLE_RATIO`, and each surviving address waits in a short queue. When the engine is free it takes one queued address and looks it up in four regions of one shared single-ported tag store. The four lookups run one after another. Each region keeps least-recently-used order with the same associativity as the main cache.

Each lookup records its result by LRU stack position. A hit at position p is also a hit for every configuration with more than p ways. Each region also counts its lookups, so the miss count for w ways is the access count minus the hits at positions 0..w-1. Software reads any counter through a small select port and can clear all of them at once.

Top module: `mssp_profiler`

## Requirements
- R1: After reset `busy` is 0 and every hit counter and access counter reads 0.
- R2: An access is profiled only when `acc_valid` is 1 and address bits [5:0] (the low log2(SAMPLE_RATIO) bits) equal `SAMPLE_SEL` (default 0). Any other access leaves all counters and `busy` unchanged.
- R3: Region r (0 = full, 1 = half, 2 = quarter, 3 = eighth) holds 128>>r sets. Its set index is address bits [12-r:6] and its tag is the address bits above bit 12-r. Two addresses that share a set in one region may fall in different sets in another region.
- R4: Accepted addresses go into a 4-entry queue. An address offered while the queue holds 4 entries (counted before that clock edge) is dropped, and the requester is never stalled.
- R5: The engine pops one address at a clock edge where it is idle and the queue is not empty. `busy` is then 1 for exactly 8 cycles: two per region, in region order 0,1,2,3. It is 0 for at least one cycle before the next pop.
- R6: A hit in region r at LRU stack position p (0 = most recent) adds 1 to hit counter (r,p). The hit entry becomes most recent, and the entries that were more recent move down by one position.
- R7: A miss replaces the entry at position 7 (the least recent) with the new tag at position 0. It changes no hit counter.
- R8: Each lookup adds 1 to the access counter of its region.
- R9: `rd_region` and `rd_pos` select hit counter (rd_region, rd_pos) onto `rd_hits`, and `rd_region` selects that region's access counter onto `rd_accesses`. Both outputs are combinational.
- R10: `clr_cnt` set to 1 zeroes all counters at the next edge. The stored tags and LRU order are kept, so an address that was looked up before the clear hits afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | A last-level-cache access is present this cycle |
| acc_addr | input | ADDR_W | Block address of that access |
| clr_cnt | input | 1 | Zero all counters |
| rd_region | input | 2 | Region select for the counter read |
| rd_pos | input | log2(WAYS) | Stack position select for the counter read |
| rd_hits | output | CNT_W | Selected hit counter |
| rd_accesses | output | CNT_W | Access counter of the selected region |
| busy | output | 1 | Engine is working through the four lookups |

## Verification
The assertions assume that `clr_cnt` is raised only while the engine is idle and the queue is empty. If a clear met a lookup in its update cycle, the access-step check would be skipped but counts could still be lost. The bench raises the clear only after it has waited for the queue and the engine to drain. Addresses may arrive on every cycle, and the queue-bound and single-hit checks rely on nothing more about them. The bench covers sparse, back-to-back and random traffic, and it deliberately overfills the queue.

// File: rtl/mssp_pkg.sv
// Shared types for the sampled tag profiler.
// Assumes: nothing beyond IEEE 1800-2017.
package mssp_pkg;
    // Lookup engine phases: waiting, tag read, tag/LRU write-back.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_READ   = 2'd1,
        ST_UPDATE = 2'd2
    } lookup_state_e;
endpackage

// File: rtl/mssp_sample_queue.sv
// Set-sampling filter followed by a small circular queue.
// An address is accepted when its low SMP_W bits equal SAMPLE_SEL and the
// queue is not full; otherwise it is dropped. Assumes pop only when !empty.
module mssp_sample_queue #(
    parameter int ADDR_W     = 32,
    parameter int DEPTH      = 4,
    parameter int SMP_W      = 6,
    parameter int SAMPLE_SEL = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic              pop,
    output logic              empty,
    output logic [ADDR_W-1:0] head
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [ADDR_W-1:0] slots [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  count;
    logic              full, push;

    // Filter match and room check decide acceptance.
    always_comb begin
        full  = (count == CNT_W'(DEPTH));
        empty = (count == '0);
        push  = in_valid && (in_addr[SMP_W-1:0] == SMP_W'(SAMPLE_SEL)) && !full;
        head  = slots[rd_ptr];
    end

    // Storage write for accepted addresses.
    always_ff @(posedge clk) begin
        if (push) slots[wr_ptr] <= in_addr;
    end

    // Pointer and occupancy bookkeeping with wrap at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            count <= count + CNT_W'(push) - CNT_W'(pop);
        end
    end

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));
    assert_full_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop) |=> full);
    assert_pop_nonempty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/mssp_tag_store.sv
// Single-ported tag store: one whole set (all ways) per access.
// A read returns the set on the next cycle. A set never written since reset
// reads as all-invalid with ranks equal to the way number, so the large array
// needs no reset. Assumes en/we are never asked to read and write at once.
module mssp_tag_store #(
    parameter int SETS  = 240,
    parameter int WAYS  = 8,
    parameter int TAG_W = 22
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        en,
    input  logic                        we,
    input  logic [$clog2(SETS)-1:0]     addr,
    input  logic [WAYS-1:0]             wr_valid,
    input  logic [WAYS-1:0][TAG_W-1:0]  wr_tag,
    input  logic [WAYS-1:0][$clog2(WAYS)-1:0] wr_rank,
    output logic [WAYS-1:0]             rd_valid,
    output logic [WAYS-1:0][TAG_W-1:0]  rd_tag,
    output logic [WAYS-1:0][$clog2(WAYS)-1:0] rd_rank
);
    localparam int POS_W = $clog2(WAYS);

    logic [WAYS-1:0]             valid_mem [SETS];
    logic [WAYS-1:0][TAG_W-1:0]  tag_mem   [SETS];
    logic [WAYS-1:0][POS_W-1:0]  rank_mem  [SETS];
    logic [SETS-1:0]             touched;

    // Array write port.
    always_ff @(posedge clk) begin
        if (en && we) begin
            valid_mem[addr] <= wr_valid;
            tag_mem[addr]   <= wr_tag;
            rank_mem[addr]  <= wr_rank;
        end
    end

    // Per-set "written since reset" flags.
    always_ff @(posedge clk) begin
        if (!rst_n)          touched       <= '0;
        else if (en && we)   touched[addr] <= 1'b1;
    end

    // Registered read, substituting the fresh-set image when untouched.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= '0;
            rd_tag   <= '0;
            for (int w = 0; w < WAYS; w++) rd_rank[w] <= POS_W'(w);
        end else if (en && !we) begin
            rd_tag <= tag_mem[addr];
            if (touched[addr]) begin
                rd_valid <= valid_mem[addr];
                rd_rank  <= rank_mem[addr];
            end else begin
                rd_valid <= '0;
                for (int w = 0; w < WAYS; w++) rd_rank[w] <= POS_W'(w);
            end
        end
    end
endmodule

// File: rtl/mssp_lru_update.sv
// Combinational hit detection and LRU rank update for one set.
// Ranks form a permutation of 0..WAYS-1 (0 = most recent). On a hit the hit
// way goes to 0 and younger ways age by one; on a miss the rank WAYS-1 way is
// replaced and every other way ages by one.
module mssp_lru_update #(
    parameter int WAYS  = 8,
    parameter int TAG_W = 22
) (
    input  logic [WAYS-1:0]             in_valid,
    input  logic [WAYS-1:0][TAG_W-1:0]  in_tag,
    input  logic [WAYS-1:0][$clog2(WAYS)-1:0] in_rank,
    input  logic [TAG_W-1:0]            look_tag,
    output logic [WAYS-1:0]             hit_vec,
    output logic                        hit,
    output logic [$clog2(WAYS)-1:0]     hit_pos,
    output logic [WAYS-1:0]             out_valid,
    output logic [WAYS-1:0][TAG_W-1:0]  out_tag,
    output logic [WAYS-1:0][$clog2(WAYS)-1:0] out_rank
);
    localparam int POS_W = $clog2(WAYS);
    localparam logic [POS_W-1:0] OLDEST = POS_W'(WAYS - 1);

    // One tag comparator per way.
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = in_valid[w] && (in_tag[w] == look_tag);
    end

    logic [POS_W-1:0] limit;

    // Hit position, then new ranks, tags and valid bits.
    always_comb begin
        hit     = |hit_vec;
        hit_pos = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w]) hit_pos = hit_pos | in_rank[w];
        end
        limit = hit ? hit_pos : OLDEST;
        for (int w = 0; w < WAYS; w++) begin
            out_valid[w] = in_valid[w];
            out_tag[w]   = in_tag[w];
            out_rank[w]  = in_rank[w];
            if (hit ? hit_vec[w] : (in_rank[w] == OLDEST)) begin
                out_valid[w] = 1'b1;
                out_tag[w]   = look_tag;
                out_rank[w]  = '0;
            end else if (in_rank[w] < limit) begin
                out_rank[w]  = in_rank[w] + 1'b1;
            end
        end
    end
endmodule

// File: rtl/mssp_profiler.sv
// Sampled tag profiler for four emulated cache sizes (1, 1/2, 1/4, 1/8 of the
// main cache's sets). Filtered addresses are queued; each is looked up in four
// regions of one single-ported tag store, region 0 first, two cycles each
// (read, write-back). Hits are counted per region and per LRU stack position.
// Assumes MAIN_SETS and SAMPLE_RATIO are powers of two with
// MAIN_SETS >= 8*SAMPLE_RATIO, and clr_cnt is raised only while idle.
module mssp_profiler #(
    parameter int ADDR_W       = 32,
    parameter int MAIN_SETS    = 8192,
    parameter int SAMPLE_RATIO = 64,
    parameter int SAMPLE_SEL   = 0,
    parameter int WAYS         = 8,
    parameter int QUEUE_DEPTH  = 4,
    parameter int CNT_W        = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    acc_valid,
    input  logic [ADDR_W-1:0]       acc_addr,
    input  logic                    clr_cnt,
    input  logic [1:0]              rd_region,
    input  logic [$clog2(WAYS)-1:0] rd_pos,
    output logic [CNT_W-1:0]        rd_hits,
    output logic [CNT_W-1:0]        rd_accesses,
    output logic                    busy
);
    import mssp_pkg::*;

    localparam int REGIONS    = 4;
    localparam int MAIN_IDX_W = $clog2(MAIN_SETS);
    localparam int SMP_W      = $clog2(SAMPLE_RATIO);
    localparam int FULL_SETS  = MAIN_SETS / SAMPLE_RATIO;
    localparam int TOTAL_SETS = 2 * FULL_SETS - FULL_SETS / 8;
    localparam int SET_AW     = $clog2(TOTAL_SETS);
    localparam int TAG_W      = ADDR_W - (MAIN_IDX_W - (REGIONS - 1));
    localparam int POS_W      = $clog2(WAYS);

    lookup_state_e     state;
    logic [1:0]        region;
    logic [ADDR_W-1:0] cur_addr;
    logic              q_empty, q_pop;
    logic [ADDR_W-1:0] q_head;

    mssp_sample_queue #(
        .ADDR_W(ADDR_W), .DEPTH(QUEUE_DEPTH), .SMP_W(SMP_W), .SAMPLE_SEL(SAMPLE_SEL)
    ) queue_i (
        .clk(clk), .rst_n(rst_n), .in_valid(acc_valid), .in_addr(acc_addr),
        .pop(q_pop), .empty(q_empty), .head(q_head)
    );

    // Region address mapping: base offset plus masked index, tag above it.
    logic [ADDR_W-1:0] idx_bits, idx_mask, reg_base;
    logic [SET_AW-1:0] set_addr;
    logic [TAG_W-1:0]  look_tag;
    always_comb begin
        idx_bits = cur_addr >> SMP_W;
        idx_mask = ADDR_W'(FULL_SETS >> region) - ADDR_W'(1);
        reg_base = ADDR_W'(2 * FULL_SETS) - ADDR_W'((2 * FULL_SETS) >> region);
        set_addr = SET_AW'(reg_base + (idx_bits & idx_mask));
        look_tag = TAG_W'(cur_addr >> (MAIN_IDX_W - 32'(region)));
    end

    logic [WAYS-1:0]            rd_valid, nx_valid, hit_vec;
    logic [WAYS-1:0][TAG_W-1:0] rd_tag, nx_tag;
    logic [WAYS-1:0][POS_W-1:0] rd_rank, nx_rank;
    logic                       hit;
    logic [POS_W-1:0]           hit_pos;

    mssp_tag_store #(.SETS(TOTAL_SETS), .WAYS(WAYS), .TAG_W(TAG_W)) store_i (
        .clk(clk), .rst_n(rst_n),
        .en(state != ST_IDLE), .we(state == ST_UPDATE), .addr(set_addr),
        .wr_valid(nx_valid), .wr_tag(nx_tag), .wr_rank(nx_rank),
        .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_rank(rd_rank)
    );

    mssp_lru_update #(.WAYS(WAYS), .TAG_W(TAG_W)) lru_i (
        .in_valid(rd_valid), .in_tag(rd_tag), .in_rank(rd_rank), .look_tag(look_tag),
        .hit_vec(hit_vec), .hit(hit), .hit_pos(hit_pos),
        .out_valid(nx_valid), .out_tag(nx_tag), .out_rank(nx_rank)
    );

    assign q_pop = (state == ST_IDLE) && !q_empty;
    assign busy  = (state != ST_IDLE);

    // Sequencer: pop, then read/write-back for regions 0..3.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            region   <= '0;
            cur_addr <= '0;
        end else begin
            case (state)
                ST_IDLE: if (q_pop) begin
                    cur_addr <= q_head;
                    region   <= '0;
                    state    <= ST_READ;
                end
                ST_READ: state <= ST_UPDATE;
                ST_UPDATE: begin
                    region <= region + 1'b1;
                    state  <= (region == 2'(REGIONS - 1)) ? ST_IDLE : ST_READ;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    logic [CNT_W-1:0] hit_cnt [REGIONS][WAYS];
    logic [CNT_W-1:0] acc_cnt [REGIONS];

    // Statistics: per-region access count and per-position hit count.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_cnt) begin
            for (int r = 0; r < REGIONS; r++) begin
                acc_cnt[r] <= '0;
                for (int p = 0; p < WAYS; p++) hit_cnt[r][p] <= '0;
            end
        end else if (state == ST_UPDATE) begin
            acc_cnt[region] <= acc_cnt[region] + CNT_W'(1);
            if (hit) hit_cnt[region][hit_pos] <= hit_cnt[region][hit_pos] + CNT_W'(1);
        end
    end

    // Software read selection.
    assign rd_hits     = hit_cnt[rd_region][rd_pos];
    assign rd_accesses = acc_cnt[rd_region];

    assert_single_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_UPDATE) |-> $onehot0(hit_vec));
    assert_pop_starts_R5: assert property (@(posedge clk) disable iff (!rst_n)
        q_pop |=> (busy && region == 2'd0));
    assert_busy_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_UPDATE && region == 2'd3) |=> !busy);
    assert_acc_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_UPDATE && !clr_cnt) |=>
        (acc_cnt[$past(region)] == $past(acc_cnt[region]) + CNT_W'(1)));
    assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_cnt |=> (acc_cnt[0] == '0 && hit_cnt[0][0] == '0 && acc_cnt[3] == '0));
endmodule

// File: tb/mssp_profiler_tb.sv
`timescale 1ns/1ps
module mssp_profiler_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        clr_cnt = 1'b0;
    logic [1:0]  rd_region = '0;
    logic [2:0]  rd_pos = '0;
    logic [31:0] rd_hits, rd_accesses;
    logic        busy;

    int errs = 0, checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mssp_profiler dut_i (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .clr_cnt(clr_cnt), .rd_region(rd_region), .rd_pos(rd_pos),
        .rd_hits(rd_hits), .rd_accesses(rd_accesses), .busy(busy)
    );

    // ---------------- behavioural reference ----------------
    int unsigned m_stack [4][128][8];
    int          m_fill  [4][128];
    int          m_hit   [4][8];
    int          m_acc   [4];
    int unsigned m_q [$];
    int          m_phase = 0;

    function automatic void m_lookup(int unsigned a);
        for (int r = 0; r < 4; r++) begin
            int s, pos;
            int unsigned t;
            s = int'((a >> 6) & ((128 >> r) - 1));
            t = a >> (13 - r);
            pos = -1;
            for (int i = 0; i < m_fill[r][s]; i++) if (pos < 0 && m_stack[r][s][i] == t) pos = i;
            m_acc[r]++;
            if (pos >= 0) begin
                m_hit[r][pos]++;
            end else begin
                if (m_fill[r][s] < 8) m_fill[r][s]++;
                pos = m_fill[r][s] - 1;
            end
            for (int i = pos; i > 0; i--) m_stack[r][s][i] = m_stack[r][s][i-1];
            m_stack[r][s][0] = t;
        end
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_q.delete();
            m_phase = 0;
            for (int r = 0; r < 4; r++) begin
                m_acc[r] = 0;
                for (int p = 0; p < 8; p++) m_hit[r][p] = 0;
                for (int s = 0; s < 128; s++) m_fill[r][s] = 0;
            end
        end else begin
            bit push;
            push = acc_valid && (acc_addr[5:0] == 6'd0) && (m_q.size() < 4);
            if (m_phase == 0 && m_q.size() > 0) begin
                m_lookup(m_q.pop_front());
                m_phase = 1;
            end else if (m_phase != 0) begin
                m_phase = (m_phase == 8) ? 0 : m_phase + 1;
            end
            if (push) m_q.push_back(acc_addr);
            if (clr_cnt) begin
                for (int r = 0; r < 4; r++) begin
                    m_acc[r] = 0;
                    for (int p = 0; p < 8; p++) m_hit[r][p] = 0;
                end
            end
        end
    end

    // ---------------- checking helpers ----------------
    task automatic chk(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // R5: busy compared with the reference on every cycle.
    always @(negedge clk) begin
        if (rst_n && !done) chk(busy == (m_phase != 0), "R5 busy per cycle", busy, m_phase != 0);
    end

    task automatic read_cnt(int r, int p, output int h, output int a);
        @(negedge clk);
        rd_region = 2'(r);
        rd_pos    = 3'(p);
        #1;
        h = int'(rd_hits);
        a = int'(rd_accesses);
    endtask

    // R9: sweep every counter through the read port against the reference.
    task automatic check_all(string req);
        for (int r = 0; r < 4; r++) begin
            for (int p = 0; p < 8; p++) begin
                int h, a;
                read_cnt(r, p, h, a);
                chk(h == m_hit[r][p], {req, " R9 hit counter"}, h, m_hit[r][p]);
                if (p == 0) chk(a == m_acc[r], {req, " R8 access counter"}, a, m_acc[r]);
            end
        end
    endtask

    task automatic put(int unsigned a);
        acc_valid = 1'b1;
        acc_addr  = a;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic drain();
        while (m_q.size() != 0 || m_phase != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic one(int unsigned a);
        put(a);
        drain();
    endtask

    task automatic clear();
        @(negedge clk);
        clr_cnt = 1'b1;
        @(negedge clk);
        clr_cnt = 1'b0;
    endtask

    // ---------------- stimulus ----------------
    initial begin
        int h, a;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R1 busy after reset", busy, 0);
        check_all("R1 reset");

        // R2: non-matching addresses are ignored.
        for (int k = 1; k < 12; k++) put(32'h0000_3000 | k);
        drain();
        chk(busy == 1'b0, "R2 busy after filtered", busy, 0);
        check_all("R2 filtered");

        // R7/R8: first access misses everywhere; R6: repeat hits at position 0.
        one(32'h0000_0A00);
        read_cnt(0, 0, h, a);
        chk(a == 1 && h == 0, "R7 single miss", a * 10 + h, 10);
        one(32'h0000_0A00);
        read_cnt(3, 0, h, a);
        chk(h == 1, "R6 repeat hit pos0 eighth", h, 1);
        check_all("R6 repeat");

        // R6: stack distance 2 in set 1 of full and half regions.
        clear();
        one(32'h0000_2040); one(32'h0000_4040); one(32'h0000_6040); one(32'h0000_2040);
        read_cnt(0, 2, h, a);
        chk(h == 1, "R6 depth-2 hit full", h, 1);
        read_cnt(1, 2, h, a);
        chk(h == 1, "R6 depth-2 hit half", h, 1);

        // R3: addresses split in full region, share a set in half.
        clear();
        one(32'h0000_0140); one(32'h0000_1140); one(32'h0000_0140);
        read_cnt(0, 0, h, a);
        chk(h == 1, "R3 full region separate sets", h, 1);
        read_cnt(1, 1, h, a);
        chk(h == 1, "R3 half region shared set", h, 1);
        check_all("R3 mapping");

        // R7: nine distinct tags in one set evict the first.
        clear();
        for (int k = 1; k <= 9; k++) one((k << 13) | (9 << 6));
        one((1 << 13) | (9 << 6));
        begin
            int sum;
            sum = 0;
            for (int p = 0; p < 8; p++) begin read_cnt(0, p, h, a); sum += h; end
            chk(sum == 0 && a == 10, "R7 eviction of least recent", sum * 100 + a, 10);
        end
        check_all("R7 eviction");

        // R4: back-to-back burst of 8 into a 4-entry queue accepts 5.
        clear();
        for (int k = 0; k < 8; k++) begin
            acc_valid = 1'b1;
            acc_addr  = (k << 6) | 32'h0010_0000;
            @(negedge clk);
        end
        acc_valid = 1'b0;
        drain();
        read_cnt(0, 0, h, a);
        chk(a == 5, "R4 drops when full", a, 5);
        check_all("R4 burst");

        // R10: clear zeroes counters but keeps tags.
        clear();
        check_all("R10 cleared");
        one(32'h0000_0A00);
        read_cnt(0, 0, h, a);
        chk(h == 1, "R10 tags kept across clear", h, 1);

        // Mixed random traffic.
        for (int i = 0; i < 600; i++) begin
            int unsigned r;
            r = $urandom;
            if ($urandom % 2 == 0) r[5:0] = 6'd0;
            r[31:16] = 16'(r[31:16] % 5);
            acc_valid = ($urandom % 3 != 0);
            acc_addr  = r;
            @(negedge clk);
        end
        acc_valid = 1'b0;
        drain();
        check_all("R6 R7 random");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errs++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule